// File: doc/BRIEF.md
# Programmable-Length Loop Filter Counter

This block is the loop filter of a first-order all-digital phase-locked loop. It runs on the fast filter clock. A single direction input, driven by the phase detector, makes it count up or down. When the count runs past the top of its active range, the block emits a one-cycle carry pulse. When it runs below zero, it emits a one-cycle borrow pulse. These pulses drive a later stage that advances or retards the recovered clock.

A 4-bit length select S picks the number of active counter stages. A nonzero S gives S+2 stages, so the range runs from 3 stages (S=1) to 17 stages (S=15). A short counter gives a wide loop bandwidth and a fast lock. A long counter gives a narrow bandwidth and a slow lock. S=0 stops the counter. The select may be changed while the loop runs, so the bandwidth can be retuned on the fly.

After reset, the count is seeded to the middle of the active range. The first carry and the first borrow are then about equally far away.

Top module: `lfc_top`

## Requirements
- R1: While rst_n is low, carry_p and borrow_p are low. On the first clock edge after reset at which S is nonzero, the count is loaded with 2^(S+1) and no pulse is produced. Seeding waits as long as S stays 0.
- R2: With dir_dn=0, each counting edge adds one. Stepping up from the maximum 2^(S+2)-1 wraps the count to 0 and raises carry_p for the cycle after that edge.
- R3: With dir_dn=1, each counting edge subtracts one. Stepping down from 0 wraps the count to 2^(S+2)-1 and raises borrow_p for the cycle after that edge.
- R4: For S from 1 to 15 the counter is S+2 stages long. Counting steadily in one direction produces one pulse every 2^(S+2) edges.
- R5: While S=0, the count holds its value and neither pulse appears.
- R6: On an edge where S differs from the value seen on the previous edge, the count is reduced modulo 2^(S_new+2) instead of stepping, and no pulse is produced. Re-enabling from S=0 counts as such a change.
- R7: carry_p and borrow_p are never high together, and each is high for exactly one cycle at a time.
- R8: Count bits at and above position S+2 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| dir_dn | input | 1 | Count direction: 0 counts up, 1 counts down |
| len_sel | input | 4 | Length select S (0 stops the counter, otherwise S+2 stages) |
| carry_p | output | 1 | One-cycle pulse when the count wraps upward |
| borrow_p | output | 1 | One-cycle pulse when the count wraps downward |

## Verification
The count itself never reaches a port. A wrong internal value shows up only as a change in the number of edges before the next carry or borrow. That difference can take up to one full period, 2^(S+2) edges, to appear. The bench therefore measures the exact edge distance to each pulse from known starting states: after reseeding, after a wrap, after a pause with S=0, and after narrowing or widening the length. A stale high bit, a skipped mask edge or a wrong seed each shifts that distance by a predictable amount. The checker also watches the count register directly for stray high bits, so such a fault is flagged on the edge where it appears.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
   // Number of active stages for a given select value (0 when stopped).
   function automatic int unsigned stages_of(input int unsigned sel, input int unsigned min_st);
      return (sel == 0) ? 0 : sel + min_st - 1;
   endfunction

   // All-ones mask over the active stages, computed independently of the decoder.
   function automatic logic [31:0] mask_of(input int unsigned sel, input int unsigned min_st);
      int unsigned st;
      st = stages_of(sel, min_st);
      return (st == 0) ? 32'd0 : ((32'd1 << st) - 32'd1);
   endfunction
endpackage

// File: rtl/lfc_len_decode.sv
module lfc_len_decode #(
   parameter int SEL_W  = 4,
   parameter int CNT_W  = 17,
   parameter int MIN_ST = 3
) (
   input  logic [SEL_W-1:0] sel,
   output logic             en,
   output logic [CNT_W-1:0] mask,
   output logic [CNT_W-1:0] mid
);
   localparam int TOP_STG = MIN_ST - 1;

   int sel_i;
   assign sel_i = int'(sel);
   assign en    = (sel != '0);

   // One decode slice per counter stage: active stage, and midpoint bit.
   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      localparam int I = i;
      assign mask[i] = en && (I < sel_i + TOP_STG);
      assign mid[i]  = en && (I == sel_i + TOP_STG - 1);
   end
endmodule

// File: rtl/lfc_ctrl.sv
module lfc_ctrl #(
   parameter int SEL_W = 4
) (
   input  logic             clk_k,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic             seed,
   output logic             chg,
   output logic [SEL_W-1:0] sel_q
);
   logic seed_q;

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         seed_q <= 1'b1;
      end else begin
         sel_q <= sel;
         if (en) seed_q <= 1'b0;
      end
   end

   assign seed = en && seed_q;
   assign chg  = en && (sel != sel_q);
endmodule

// File: rtl/lfc_updown.sv
module lfc_updown #(
   parameter int CNT_W = 17
) (
   input  logic             clk_k,
   input  logic             rst_n,
   input  logic             en,
   input  logic             seed,
   input  logic             chg,
   input  logic             dn,
   input  logic [CNT_W-1:0] mask,
   input  logic [CNT_W-1:0] mid,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_up,
   output logic             wrap_dn
);
   logic             step;
   logic             at_top;
   logic             at_bot;
   logic [CNT_W-1:0] cnt_d;

   assign step    = en && !seed && !chg;
   assign at_top  = (cnt_q == mask);
   assign at_bot  = (cnt_q == '0);
   assign wrap_up = step && !dn && at_top;
   assign wrap_dn = step && dn && at_bot;

   always_comb begin
      cnt_d = cnt_q;
      if (seed)       cnt_d = mid;
      else if (chg)   cnt_d = cnt_q & mask;
      else if (step) begin
         if (dn) cnt_d = at_bot ? mask : cnt_q - 1'b1;
         else    cnt_d = at_top ? '0   : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/lfc_pulse.sv
module lfc_pulse (
   input  logic clk_k,
   input  logic rst_n,
   input  logic wrap_up,
   input  logic wrap_dn,
   output logic carry_p,
   output logic borrow_p
);
   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         carry_p  <= 1'b0;
         borrow_p <= 1'b0;
      end else begin
         carry_p  <= wrap_up;
         borrow_p <= wrap_dn;
      end
   end
endmodule

// File: rtl/lfc_top.sv
module lfc_top #(
   parameter int SEL_W  = 4,
   parameter int MIN_ST = 3,
   parameter int CNT_W  = MIN_ST + (1 << SEL_W) - 2
) (
   input  logic             clk_k,
   input  logic             rst_n,
   input  logic             dir_dn,
   input  logic [SEL_W-1:0] len_sel,
   output logic             carry_p,
   output logic             borrow_p
);
   localparam int MAX_ST = MIN_ST + (1 << SEL_W) - 2;

   if (CNT_W != MAX_ST) begin : g_bad_width
      $error("lfc_top: CNT_W must equal the longest selectable length");
   end
   if (MIN_ST < 2 || CNT_W > 31) begin : g_bad_range
      $error("lfc_top: stage range out of bounds");
   end

   logic             en;
   logic             seed;
   logic             chg;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] mid;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap_up;
   logic             wrap_dn;

   lfc_len_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W), .MIN_ST(MIN_ST)) u_dec (
      .sel(len_sel), .en(en), .mask(mask), .mid(mid)
   );

   lfc_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk_k(clk_k), .rst_n(rst_n), .sel(len_sel), .en(en),
      .seed(seed), .chg(chg), .sel_q(sel_q)
   );

   lfc_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk_k(clk_k), .rst_n(rst_n), .en(en), .seed(seed), .chg(chg),
      .dn(dir_dn), .mask(mask), .mid(mid), .cnt_q(cnt_q),
      .wrap_up(wrap_up), .wrap_dn(wrap_dn)
   );

   lfc_pulse u_pls (
      .clk_k(clk_k), .rst_n(rst_n), .wrap_up(wrap_up), .wrap_dn(wrap_dn),
      .carry_p(carry_p), .borrow_p(borrow_p)
   );
endmodule

// File: rtl/lfc_chk.sv
module lfc_chk #(
   parameter int SEL_W  = 4,
   parameter int MIN_ST = 3,
   parameter int CNT_W  = 17
) (
   input logic             clk_k,
   input logic             rst_n,
   input logic             dir_dn,
   input logic [SEL_W-1:0] len_sel,
   input logic             carry_p,
   input logic             borrow_p,
   input logic [CNT_W-1:0] cnt,
   input logic [SEL_W-1:0] sel_reg
);
   import lfc_pkg::*;

   logic [SEL_W-1:0] prev_sel;
   logic [31:0]      lim;

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) prev_sel <= '0;
      else        prev_sel <= len_sel;
   end

   assign lim = mask_of(int'(sel_reg), MIN_ST);

   // R2
   carry_dir_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      carry_p |-> $past(!dir_dn));
   // R3
   borrow_dir_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      borrow_p |-> $past(dir_dn));
   // R5
   stopped_quiet_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      (len_sel == '0) |=> (!carry_p && !borrow_p));
   // R6
   resize_quiet_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      (len_sel != prev_sel) |=> (!carry_p && !borrow_p));
   // R7
   pulse_excl_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      !(carry_p && borrow_p));
   // R7
   carry_width_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      carry_p |=> !carry_p);
   // R7
   borrow_width_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      borrow_p |=> !borrow_p);
   // R8
   high_bits_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
      (sel_reg != '0) |-> ((32'(cnt) & ~lim) == 32'd0));
endmodule

bind lfc_top lfc_chk #(.SEL_W(SEL_W), .MIN_ST(MIN_ST), .CNT_W(CNT_W)) u_chk (
   .clk_k(clk_k), .rst_n(rst_n), .dir_dn(dir_dn), .len_sel(len_sel),
   .carry_p(carry_p), .borrow_p(borrow_p), .cnt(cnt_q), .sel_reg(sel_q)
);

// File: tb/sim_lfc_top.sv
module sim_lfc_top;
   logic       clk_k = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir_dn = 1'b0;
   logic [3:0] len_sel = 4'd1;
   logic       carry_p;
   logic       borrow_p;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #4 clk_k = ~clk_k;

   lfc_top u0 (
      .clk_k(clk_k), .rst_n(rst_n), .dir_dn(dir_dn), .len_sel(len_sel),
      .carry_p(carry_p), .borrow_p(borrow_p)
   );

   always @(posedge clk_k) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung (actual cycle %0d, expected below 190000)", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [3:0] s);
      @(negedge clk_k);
      rst_n   = 1'b0;
      len_sel = s;
      dir_dn  = 1'b0;
      @(negedge clk_k);
      @(negedge clk_k);
      check_int("R1 carry low in reset", int'(carry_p), 0);
      check_int("R1 borrow low in reset", int'(borrow_p), 0);
      rst_n = 1'b1;
   endtask

   // Edges until the target pulse; counts any wrong-direction pulse.
   task automatic run_until(input string req, input logic dn, input int exp);
      int n = 0;
      int wrong = 0;
      dir_dn = dn;
      while (n < 70000) begin
         @(negedge clk_k);
         n++;
         if ((dn ? carry_p : borrow_p) == 1'b1) wrong++;
         if ((dn ? borrow_p : carry_p) == 1'b1) break;
      end
      check_int(req, n, exp);
      check_int({req, " no opposite pulse"}, wrong, 0);
   endtask

   // Steps with no pulse expected.
   task automatic quiet(input string req, input logic dn, input int n, input logic alt);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         dir_dn = alt ? logic'(k % 2) : dn;
         @(negedge clk_k);
         if (carry_p || borrow_p) seen++;
      end
      check_int(req, seen, 0);
   endtask

   task automatic t_seed_and_period;
      do_reset(4'd1);
      // R1 seed to 4 then R2 carry after 4 up steps
      run_until("R1 R2 seed midpoint S=1 up", 1'b0, 5);
      // R4 full period of 8
      run_until("R4 period S=1 up", 1'b0, 8);
   endtask

   task automatic t_borrow;
      // count is 0: R3 one down step borrows, then full period
      run_until("R3 borrow from zero", 1'b1, 1);
      run_until("R3 R4 period S=1 down", 1'b1, 8);
   endtask

   task automatic t_stop;
      // count 7; R5 stopped holds value and is quiet
      len_sel = 4'd0;
      quiet("R5 stopped no pulses", 1'b0, 30, 1'b0);
      len_sel = 4'd1;
      run_until("R5 R6 hold then re-enable", 1'b0, 2);
   endtask

   task automatic t_narrow;
      // count 0; S=3, change edge + 20 up steps -> 20
      len_sel = 4'd3;
      quiet("R6 widen quiet", 1'b0, 21, 1'b0);
      len_sel = 4'd1;
      // R8 20 mod 8 = 4, carry after mask edge + 4 steps
      run_until("R6 R8 narrow reduces modulo", 1'b0, 5);
   endtask

   task automatic t_widen;
      quiet("R2 step to 4", 1'b0, 4, 1'b0);
      len_sel = 4'd2;
      run_until("R6 R4 widen keeps value", 1'b0, 13);
   endtask

   task automatic t_alternate;
      quiet("R7 alternating direction quiet", 1'b0, 40, 1'b1);
   endtask

   task automatic t_long;
      do_reset(4'd15);
      run_until("R4 R1 seventeen stages up", 1'b0, 65537);
      do_reset(4'd6);
      run_until("R1 R3 S=6 down from midpoint", 1'b1, 130);
   endtask

   task automatic t_late_enable;
      do_reset(4'd0);
      quiet("R1 R5 no seed while stopped", 1'b0, 10, 1'b0);
      len_sel = 4'd2;
      run_until("R1 late seed S=2", 1'b0, 9);
   endtask

   initial begin
      t_seed_and_period();
      t_borrow();
      t_stop();
      t_narrow();
      t_widen();
      t_alternate();
      t_long();
      t_late_enable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule